// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block collects up to 24 interrupt request sources, held as three 8-bit request registers, and tells the CPU which one to service. Each source carries two enable bits, a high one and a low one, which together either switch the source off or place it at one of three priority levels. When several enabled requests are pending, the highest level wins. Among sources at the same level, a fixed index order settles the tie: index 0 (the watchdog source) ranks first and the last index (the port C0 source) ranks last.

Port sources turn pin edges into request bits. A per-source select bit picks the rising or the falling edge. Selected port sources can also be set to respond to both edges. Software writes the request registers directly to raise or drop requests. A request edge that arrives in the same cycle as such a write is still recorded. A global enable gates the request output to the CPU. Software sets it through a control write or a return-from-interrupt strobe, and it is cleared by a disable strobe, by a control write, or by the CPU acknowledge. On acknowledge the controller presents the winning vector index, clears that one request bit and drops the global enable on the same clock edge.

Register window (index k selects request register k, covering sources 8k to 8k+7; bit b of a register belongs to source 8k+b):
- Address k: request register k.
- Address 3+k: high-enable register k.
- Address 6+k: low-enable register k.
- Address 9+k: edge-select register k.
- Address 12+k: both-edge register k.
- Address 15: control register, with the global enable in bit 7.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The enable pair {high,low} of a source decodes as follows: 00 means disabled, so a pending request never raises `irq_o` and is never chosen. 01 is level 1, 10 is level 2 and 11 is level 3, the highest level.
- R2: When enabled pending requests sit at different levels, `vec_o` gives the index of a request at the highest level present, whatever its index.
- R3: When the top level present is held by several pending requests, `vec_o` gives the lowest index among them. Index 0 outranks all others and index 23 ranks last.
- R4: `irq_o` is high exactly when the global enable is set and at least one pending request has a nonzero level.
- R5: When `ack_i` is high while `irq_o` is high, the next clock edge clears only the request bit at `vec_o` and also clears the global enable.
- R6: When `ack_i` is high while `irq_o` is low, no request bit and no enable changes.
- R7: The global enable (read at address 15, bit 7) is set by `iret_i` or by a control write with bit 7 = 1. It is cleared by `di_i` or by a control write with bit 7 = 0. A clear that arrives in the same cycle as a set takes precedence.
- R8: Port sources (indices 8 to 23) request on a rising edge when their edge-select bit is 0 and on a falling edge when it is 1. The other sources always request on a rising edge. For them, edge-select bits read back 0.
- R9: Sources 20 to 23, when their both-edge bit is 1, request on both edges. Both-edge bits of other sources read back 0 and have no effect.
- R10: A write to a request register replaces its bits with the written data. A source edge in the same cycle still sets its bit.
- R11: A request bit stays set until it is acknowledged or cleared by a write.
- R12: After reset, all request, enable, edge and both-edge registers and the global enable are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 24 | Raw request lines, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| iret_i | input | 1 | Return-from-interrupt strobe, sets global enable |
| di_i | input | 1 | Disable strobe, clears global enable |
| ack_i | input | 1 | CPU acknowledge |
| irq_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 5 | Index of the winning request |
| gie_o | output | 1 | Global enable state |

## Verification
The bench builds the controller with its default parameters: three 8-bit registers, port sources at indices 8 to 23, and both-edge capability at indices 20 to 23. With these values the bench can reach the first and last index tie at level 3, edges of non-port, port and both-edge sources, and masked writes to the edge and both-edge registers. Because the source count is small, every source can be addressed directly, so the level-over-index ordering and the same-cycle write-versus-edge race are each driven on chosen sources.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_OFF = 2'd0;

  function automatic lvl_t lvl_of(input logic hi, input logic lo);
    return {hi, lo};
  endfunction

  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic fall_sel, input logic both_sel);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both_sel) return rise | fall;
    return fall_sel ? fall : rise;
  endfunction
endpackage

// File: rtl/irq_edge_unit.sv
module irq_edge_unit #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] fall_sel,
  input  logic [NSRC-1:0] both_sel,
  output logic [NSRC-1:0] evt_o
);
  import irq_pkg::*;
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_det
    assign evt_o[i] = edge_hit(src_i[i], prev_q[i], fall_sel[i], both_sel[i]);
  end

  // R8: a line held steady produces no request event
  p_steady_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == prev_q) |-> (evt_o == '0));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_REG = 3,
  parameter int REG_W = 8,
  parameter int AW = 4,
  parameter logic [NUM_REG*REG_W-1:0] PORT_MASK = 24'hFFFF00,
  parameter logic [NUM_REG*REG_W-1:0] BOTH_MASK = 24'hF00000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic                     iret_i,
  input  logic                     di_i,
  input  logic                     ack_take,
  output logic [NUM_REG*REG_W-1:0] enh_o,
  output logic [NUM_REG*REG_W-1:0] enl_o,
  output logic [NUM_REG*REG_W-1:0] fall_o,
  output logic [NUM_REG*REG_W-1:0] both_o,
  output logic                     gie_o
);
  localparam int ENH_BASE  = NUM_REG;
  localparam int ENL_BASE  = 2 * NUM_REG;
  localparam int FALL_BASE = 3 * NUM_REG;
  localparam int BOTH_BASE = 4 * NUM_REG;
  localparam int CTRL_ADDR = 5 * NUM_REG;

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enh_o[k*REG_W +: REG_W]  <= '0;
        enl_o[k*REG_W +: REG_W]  <= '0;
        fall_o[k*REG_W +: REG_W] <= '0;
        both_o[k*REG_W +: REG_W] <= '0;
      end else if (wr_en) begin
        if (wr_addr == AW'(ENH_BASE + k))  enh_o[k*REG_W +: REG_W] <= wr_data;
        if (wr_addr == AW'(ENL_BASE + k))  enl_o[k*REG_W +: REG_W] <= wr_data;
        if (wr_addr == AW'(FALL_BASE + k))
          fall_o[k*REG_W +: REG_W] <= wr_data & PORT_MASK[k*REG_W +: REG_W];
        if (wr_addr == AW'(BOTH_BASE + k))
          both_o[k*REG_W +: REG_W] <= wr_data & BOTH_MASK[k*REG_W +: REG_W];
      end
    end
  end

  logic ctrl_wr, gie_set, gie_clr;
  assign ctrl_wr = wr_en && (wr_addr == AW'(CTRL_ADDR));
  assign gie_set = iret_i || (ctrl_wr && wr_data[REG_W-1]);
  assign gie_clr = di_i || ack_take || (ctrl_wr && !wr_data[REG_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n)       gie_o <= 1'b0;
    else if (gie_clr) gie_o <= 1'b0;
    else if (gie_set) gie_o <= 1'b1;
  end

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (di_i || ack_take) |=> !gie_o);
  p_iret_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iret_i && !di_i && !ack_take && !ctrl_wr) |=> gie_o);
  p_fall_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o & ~PORT_MASK) == '0);
  p_both_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (both_o & ~BOTH_MASK) == '0);
endmodule

// File: rtl/irq_req_regs.sv
module irq_req_regs #(
  parameter int NUM_REG = 3,
  parameter int REG_W = 8,
  parameter int AW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [NUM_REG*REG_W-1:0] evt_i,
  input  logic [NUM_REG*REG_W-1:0] ack_clr_i,
  output logic [NUM_REG*REG_W-1:0] req_o
);
  for (genvar k = 0; k < NUM_REG; k++) begin : g_bank
    logic [REG_W-1:0] base;
    assign base = (wr_en && wr_addr == AW'(k)) ? wr_data : req_o[k*REG_W +: REG_W];
    always_ff @(posedge clk) begin
      if (!rst_n) req_o[k*REG_W +: REG_W] <= '0;
      else req_o[k*REG_W +: REG_W] <= (base & ~ack_clr_i[k*REG_W +: REG_W])
                                      | evt_i[k*REG_W +: REG_W];
    end
  end

  // R10: an edge is never lost, whatever is written in the same cycle
  p_edge_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((req_o & $past(evt_i)) == $past(evt_i)));
  // R11: with no write and no acknowledge, nothing set drops
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ack_clr_i == '0) |=> ((req_o & $past(req_o)) == $past(req_o)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 24,
  parameter int VW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      req_i,
  input  logic [NSRC-1:0]      enh_i,
  input  logic [NSRC-1:0]      enl_i,
  output logic                 found_o,
  output logic [VW-1:0]        idx_o,
  output irq_pkg::lvl_t        lvl_o
);
  import irq_pkg::*;
  lvl_t eff [NSRC];

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      eff[i] = req_i[i] ? lvl_of(enh_i[i], enl_i[i]) : LVL_OFF;
  end

  // scan from the lowest rank upward so a lower index replaces at equal level
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = LVL_OFF;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i] != LVL_OFF && eff[i] >= lvl_o) begin
        found_o = 1'b1;
        lvl_o   = eff[i];
        idx_o   = VW'(i);
      end
    end
  end

  lvl_t max_lvl;
  logic tie_bad;
  always_comb begin
    max_lvl = LVL_OFF;
    tie_bad = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (eff[i] > max_lvl) max_lvl = eff[i];
      if (VW'(i) < idx_o && eff[i] == lvl_o && lvl_o != LVL_OFF) tie_bad = 1'b1;
    end
  end

  p_top_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (lvl_o == max_lvl));
  p_tie_low_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> !tie_bad);
  p_winner_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (req_i[idx_o] && (enh_i[idx_o] || enl_i[idx_o])));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_REG = 3,
  parameter int REG_W = 8,
  parameter logic [NUM_REG*REG_W-1:0] PORT_MASK = 24'hFFFF00,
  parameter logic [NUM_REG*REG_W-1:0] BOTH_MASK = 24'hF00000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_REG*REG_W-1:0]          src_i,
  input  logic                              wr_en,
  input  logic [$clog2(5*NUM_REG+1)-1:0]    wr_addr,
  input  logic [REG_W-1:0]                  wr_data,
  input  logic [$clog2(5*NUM_REG+1)-1:0]    rd_addr,
  output logic [REG_W-1:0]                  rd_data,
  input  logic                              iret_i,
  input  logic                              di_i,
  input  logic                              ack_i,
  output logic                              irq_o,
  output logic [$clog2(NUM_REG*REG_W)-1:0]  vec_o,
  output logic                              gie_o
);
  import irq_pkg::*;
  localparam int NSRC = NUM_REG * REG_W;
  localparam int AW   = $clog2(5 * NUM_REG + 1);
  localparam int VW   = $clog2(NSRC);

  logic [NSRC-1:0] enh, enl, fall_sel, both_sel, evt, req, ack_clr;
  logic            found, ack_take;
  lvl_t            win_lvl;

  irq_cfg_regs #(.NUM_REG(NUM_REG), .REG_W(REG_W), .AW(AW),
                 .PORT_MASK(PORT_MASK), .BOTH_MASK(BOTH_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .iret_i(iret_i), .di_i(di_i), .ack_take(ack_take),
    .enh_o(enh), .enl_o(enl), .fall_o(fall_sel), .both_o(both_sel), .gie_o(gie_o));

  irq_edge_unit #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .fall_sel(fall_sel),
    .both_sel(both_sel), .evt_o(evt));

  irq_req_regs #(.NUM_REG(NUM_REG), .REG_W(REG_W), .AW(AW)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_i(evt), .ack_clr_i(ack_clr), .req_o(req));

  irq_arbiter #(.NSRC(NSRC), .VW(VW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .enh_i(enh), .enl_i(enl),
    .found_o(found), .idx_o(vec_o), .lvl_o(win_lvl));

  assign irq_o    = gie_o && found;
  assign ack_take = ack_i && irq_o;
  assign ack_clr  = ack_take ? (NSRC'(1) << vec_o) : '0;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REG; k++) begin
      if (rd_addr == AW'(k))               rd_data = req[k*REG_W +: REG_W];
      if (rd_addr == AW'(NUM_REG + k))     rd_data = enh[k*REG_W +: REG_W];
      if (rd_addr == AW'(2*NUM_REG + k))   rd_data = enl[k*REG_W +: REG_W];
      if (rd_addr == AW'(3*NUM_REG + k))   rd_data = fall_sel[k*REG_W +: REG_W];
      if (rd_addr == AW'(4*NUM_REG + k))   rd_data = both_sel[k*REG_W +: REG_W];
    end
    if (rd_addr == AW'(5*NUM_REG)) rd_data = {gie_o, {(REG_W-1){1'b0}}};
  end

  p_irq_needs_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie_o && win_lvl != LVL_OFF));
  p_ack_drops_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !gie_o);
  p_ack_clears_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr));
  p_idle_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o) |-> (ack_clr == '0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/100ps
module test_irq_prio_ctrl;
  localparam int A_ENH = 3, A_ENL = 6, A_FALL = 9, A_BOTH = 12, A_CTRL = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        iret = 1'b0, di = 1'b0, ack = 1'b0;
  logic        irq;
  logic [4:0]  vec;
  logic        gie;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  logic [7:0] enh_sh [3];
  logic [7:0] enl_sh [3];

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .iret_i(iret),
    .di_i(di), .ack_i(ack), .irq_o(irq), .vec_o(vec), .gie_o(gie));

  always #2 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    rd_addr = 4'(a); #0.5; v = int'(rd_data);
  endtask

  task automatic set_lvl(int s, int l);
    enh_sh[s/8][s%8] = l[1];
    enl_sh[s/8][s%8] = l[0];
    wr(A_ENH + s/8, enh_sh[s/8]);
    wr(A_ENL + s/8, enl_sh[s/8]);
  endtask

  task automatic sw_set(int s);
    int v;
    rd(s/8, v);
    wr(s/8, v | (1 << (s%8)));
  endtask

  task automatic pulse_iret();
    iret = 1'b1; step(); iret = 1'b0;
  endtask

  // driver side of the scoreboard: queue the expected vector, then acknowledge
  task automatic do_ack(int exp_vec);
    exp_q.push_back(exp_vec);
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  // monitor side: a granted acknowledge must present the queued vector (R5)
  always @(negedge clk) begin
    if (ack && irq) begin
      if (exp_q.size() == 0) chk("R5", "unexpected grant", 1, 0);
      else chk("R5", "ack vector", int'(vec), exp_q.pop_front());
    end
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    for (int k = 0; k < 3; k++) begin enh_sh[k] = '0; enl_sh[k] = '0; end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R12 reset state
    for (int k = 0; k < 3; k++) begin rd(k, v); chk("R12", "request reg", v, 0); end
    rd(A_ENH, v); chk("R12", "high enable", v, 0);
    rd(A_CTRL, v); chk("R12", "global enable", v, 0);
    chk("R12", "irq", int'(irq), 0);

    // R4/R10/R5: single source at level 1
    set_lvl(5, 1);
    wr(A_CTRL, 8'h80);
    chk("R4", "no request yet", int'(irq), 0);
    sw_set(5);
    chk("R4", "irq with request", int'(irq), 1);
    chk("R4", "vector", int'(vec), 5);
    do_ack(5);
    rd(0, v); chk("R5", "served bit cleared", v, 0);
    chk("R5", "gie cleared by ack", int'(gie), 0);

    // R1: disabled source never interrupts; R11 it stays pending
    sw_set(3);
    wr(A_CTRL, 8'h80);
    chk("R1", "disabled source irq", int'(irq), 0);
    rd(0, v); chk("R11", "pending kept", v, 8'h08);

    // R2: level beats index
    set_lvl(2, 1);
    set_lvl(20, 3);
    sw_set(2);
    sw_set(20);
    chk("R2", "level 3 wins", int'(vec), 20);
    do_ack(20);
    rd(2, v); chk("R5", "reg2 after ack", v, 0);
    rd(0, v); chk("R5", "others untouched", v, 8'h0C);
    chk("R7", "gie off before iret", int'(gie), 0);
    pulse_iret();
    chk("R7", "iret sets gie", int'(gie), 1);
    chk("R2", "next winner", int'(vec), 2);
    do_ack(2);

    // R3: ties resolved by index
    set_lvl(9, 2);
    set_lvl(14, 2);
    sw_set(14);
    sw_set(9);
    pulse_iret();
    chk("R3", "tie at level 2", int'(vec), 9);
    do_ack(9);
    pulse_iret();
    do_ack(14);
    set_lvl(0, 3);
    set_lvl(23, 3);
    sw_set(23);
    sw_set(0);
    pulse_iret();
    chk("R3", "index 0 first", int'(vec), 0);
    do_ack(0);
    pulse_iret();
    chk("R3", "index 23 last", int'(vec), 23);
    do_ack(23);

    // R6: acknowledge without irq is ignored
    sw_set(5);
    chk("R6", "irq low", int'(irq), 0);
    ack = 1'b1; step(); ack = 1'b0;
    rd(0, v); chk("R6", "requests kept", v, 8'h28);
    chk("R6", "gie kept", int'(gie), 0);
    wr(0, 0);
    rd(0, v); chk("R10", "software clear", v, 0);

    // R8: edge selection
    src[10] = 1'b1; step();
    rd(1, v); chk("R8", "rising on port", v, 8'h04);
    wr(1, 0);
    src[10] = 1'b0; step();
    rd(1, v); chk("R8", "no falling when rising", v, 0);
    wr(A_FALL + 1, 8'h08);
    src[11] = 1'b1; step();
    rd(1, v); chk("R8", "no rising when falling", v, 0);
    src[11] = 1'b0; step();
    rd(1, v); chk("R8", "falling on port", v, 8'h08);
    wr(1, 0);
    wr(A_FALL, 8'hFF);
    rd(A_FALL, v); chk("R8", "non-port edge bits", v, 0);
    src[1] = 1'b1; step();
    rd(0, v); chk("R8", "non-port rising", v, 8'h02);
    wr(0, 0);
    src[1] = 1'b0; step();
    rd(0, v); chk("R8", "non-port ignores falling", v, 0);

    // R9: both edges
    wr(A_BOTH + 2, 8'h40);
    src[22] = 1'b1; step();
    rd(2, v); chk("R9", "both rising", v, 8'h40);
    wr(2, 0);
    src[22] = 1'b0; step();
    rd(2, v); chk("R9", "both falling", v, 8'h40);
    wr(2, 0);
    wr(A_BOTH + 1, 8'hFF);
    rd(A_BOTH + 1, v); chk("R9", "incapable both bits", v, 0);
    src[10] = 1'b1; step();
    src[10] = 1'b0; step();
    rd(1, v); chk("R9", "incapable single edge", v, 8'h04);
    wr(1, 0);

    // R10: write and edge in the same cycle
    src[12] = 1'b1;
    wr(1, 8'h00);
    rd(1, v); chk("R10", "edge survives write", v, 8'h10);
    wr(1, 8'h81);
    rd(1, v); chk("R10", "write replaces", v, 8'h81);
    wr(1, 0);

    // R7: global enable control
    wr(A_CTRL, 8'h80);
    chk("R7", "write sets", int'(gie), 1);
    di = 1'b1; step(); di = 1'b0;
    chk("R7", "di clears", int'(gie), 0);
    iret = 1'b1; di = 1'b1; step(); iret = 1'b0; di = 1'b0;
    chk("R7", "clear wins", int'(gie), 0);
    pulse_iret();
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, v); chk("R7", "write clears", v, 0);

    chk("R5", "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule